// File: doc/BRIEF.md
# Systolic Signature Comparison Array

The array holds one reference signature in each processing element (PE) of a linear chain and compares a stream of database signatures against all of them. Reference signatures and their indices are loaded by shifting them into the head of the chain, one per strobe, until every PE holds one. Database signatures, each with an index and a valid flag, enter the head and move one PE further on every enabled clock. The array can therefore take a new database signature on every cycle.

In each PE, a valid database signature is XORed with the stored reference signature, and the set bits are counted by a pipelined bit counter with a fixed latency. The distance then passes through a filter against a threshold register that can be written at run time. A distance that passes is put out as a 64-bit word that also carries the reference index and the database index. A single enable input freezes the whole array when downstream storage cannot accept more results. To use a new reference set, shift the new set in and replay the database stream.

Top module: `sig_cmp_array`

## Requirements
- R1: On an enabled edge with `statShift` high, PE 0 captures `statSigIn`/`statIdxIn` and every PE k>0 captures the signature and index that PE k-1 held before that edge. Without the strobe, the stored reference signatures do not change.
- R2: On every enabled edge, the database signature, index and valid flag move one PE down the chain, and PE 0 takes `dynSigIn`/`dynIdxIn`/`dynValid`. Valid signatures on consecutive cycles are all accepted.
- R3: The distance is the number of bit positions in which the database signature differs from the reference signature that the PE holds on the edge after the database signature arrived in it. The result appears at PE k on the (k+POP_LAT+2)-th enabled edge, counting the accepting edge as the first.
- R4: Layout of the result word: bits [63:54] hold the distance, bits [53:27] the reference index, and bits [26:0] the database index.
- R5: `resValid[k]` is raised only if the distance is not greater than the threshold. A threshold of 0 passes only identical signatures, and a threshold of SIG_W passes every valid comparison, including the all-bits-differ case.
- R6: When `thrWe` is high on a clock edge, the threshold register loads `thrData`. This happens whether or not `enable` is high. Filtering decisions made on later edges use the new value.
- R7: While `enable` is low, all PE state and all outputs hold, and `statShift` and `dynValid` are ignored. When `enable` returns high, every comparison in flight completes with no result lost or duplicated.
- R8: An empty database slot (`dynValid` low) produces no result in any PE.
- R9: Reset clears every `resValid` bit, sets the threshold to SIG_W, and clears all stored signatures and indices.
- R10: After a new reference set has been shifted in, replayed database signatures are compared against the new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global advance; low freezes the array |
| statShift | input | 1 | Shift strobe for reference signatures |
| statSigIn | input | SIG_W | Reference signature into the chain head |
| statIdxIn | input | IDX_W | Index of that reference signature |
| dynValid | input | 1 | Database signature is present |
| dynSigIn | input | SIG_W | Database signature into the chain head |
| dynIdxIn | input | IDX_W | Index of that database signature |
| thrWe | input | 1 | Write strobe for the threshold register |
| thrData | input | DIST_W | New threshold value |
| resValid | output | NUM_PE | Per-PE result valid |
| resWord | output | NUM_PE*64 | Per-PE result words, PE k at bits [64k+63:64k] |

## Verification
A reference signature left in the wrong PE, or a shift that is lost, shows up as a wrong reference index in every result word of the affected PE from the next database signature onward. A misaligned pipeline stage pairs a distance with the wrong indices, or moves `resValid` by a cycle. A bad freeze drops or repeats a result within one cycle of `enable` changing. The bench compares every PE's outputs with a behavioural model on every clock, so any such fault is flagged on the first edge where the result differs.

// File: rtl/sca_pkg.sv
package sca_pkg;
  // strobes from control into the PE chain
  typedef struct packed {
    logic adv;       // whole array advances this edge
    logic statLoad;  // reference signatures shift this edge
    logic dynLoad;   // database slot at the head is occupied
  } sca_strb_t;
endpackage

// File: rtl/sca_ctrl.sv
module sca_ctrl
  import sca_pkg::*;
#(
  parameter int SIG_W  = 32,
  parameter int DIST_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              statShift,
  input  logic              dynValid,
  input  logic              thrWe,
  input  logic [DIST_W-1:0] thrData,
  output sca_strb_t         strb,
  output logic [DIST_W-1:0] thrQ
);
  localparam logic [DIST_W-1:0] ThrReset = DIST_W'(SIG_W);

  always_comb begin
    strb.adv      = enable;
    strb.statLoad = enable & statShift;
    strb.dynLoad  = dynValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ <= ThrReset;
    end else if (thrWe) begin
      thrQ <= thrData;
    end
  end

  // R6: threshold only moves on a write strobe
  a_r6_thr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !thrWe |=> $stable(thrQ));

  // R7: no shift of reference data while frozen
  a_r7_no_load_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strb.statLoad);
endmodule

// File: rtl/sca_popcount.sv
module sca_popcount #(
  parameter int SIG_W  = 32,
  parameter int DIST_W = 10,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adv,
  input  logic [SIG_W-1:0]  vecIn,
  output logic [DIST_W-1:0] cntOut
);
  localparam int NCH  = (SIG_W + 7) / 8;
  localparam int PADW = NCH * 8;

  logic [PADW-1:0]   padded;
  logic [3:0]        chunkNext [NCH];
  logic [3:0]        chunkCnt  [NCH];
  logic [DIST_W-1:0] sumNext;
  logic [DIST_W-1:0] dly [LAT-1];

  assign padded = PADW'(vecIn);

  // stage 1: count each byte
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chunkNext[c] = '0;
      for (int b = 0; b < 8; b++) begin
        chunkNext[c] = chunkNext[c] + 4'(padded[c*8+b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) chunkCnt[c] <= '0;
    end else if (adv) begin
      for (int c = 0; c < NCH; c++) chunkCnt[c] <= chunkNext[c];
    end
  end

  // stage 2: add the byte counts
  always_comb begin
    sumNext = '0;
    for (int c = 0; c < NCH; c++) begin
      sumNext = sumNext + DIST_W'(chunkCnt[c]);
    end
  end

  // stage 2 register plus balancing delay up to LAT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT-1; i++) dly[i] <= '0;
    end else if (adv) begin
      dly[0] <= sumNext;
      for (int i = 1; i < LAT-1; i++) dly[i] <= dly[i-1];
    end
  end

  assign cntOut = dly[LAT-2];

  // R3: a count never exceeds the signature width
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cntOut <= DIST_W'(SIG_W));
endmodule

// File: rtl/sca_pe.sv
module sca_pe
  import sca_pkg::*;
#(
  parameter int SIG_W   = 32,
  parameter int IDX_W   = 27,
  parameter int DIST_W  = 10,
  parameter int POP_LAT = 2,
  localparam int RES_W  = DIST_W + 2*IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sca_strb_t         strb,
  input  logic [DIST_W-1:0] thrQ,
  input  logic [SIG_W-1:0]  statSigIn,
  input  logic [IDX_W-1:0]  statIdxIn,
  input  logic              dynVIn,
  input  logic [SIG_W-1:0]  dynSigIn,
  input  logic [IDX_W-1:0]  dynIdxIn,
  output logic [SIG_W-1:0]  statSigOut,
  output logic [IDX_W-1:0]  statIdxOut,
  output logic              dynVOut,
  output logic [SIG_W-1:0]  dynSigOut,
  output logic [IDX_W-1:0]  dynIdxOut,
  output logic              resValid,
  output logic [RES_W-1:0]  resWord
);
  logic [SIG_W-1:0]  statSig, dynSig;
  logic [IDX_W-1:0]  statIdx, dynIdx;
  logic              dynV;
  logic              vPipe [POP_LAT];
  logic [IDX_W-1:0]  sIdxPipe [POP_LAT];
  logic [IDX_W-1:0]  dIdxPipe [POP_LAT];
  logic [DIST_W-1:0] popCnt;
  logic              keep;

  // reference register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statSig <= '0;
      statIdx <= '0;
    end else if (strb.statLoad) begin
      statSig <= statSigIn;
      statIdx <= statIdxIn;
    end
  end

  // database slot register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dynV   <= 1'b0;
      dynSig <= '0;
      dynIdx <= '0;
    end else if (strb.adv) begin
      dynV   <= dynVIn;
      dynSig <= dynSigIn;
      dynIdx <= dynIdxIn;
    end
  end

  sca_popcount #(
    .SIG_W (SIG_W),
    .DIST_W(DIST_W),
    .LAT   (POP_LAT)
  ) u_pop (
    .clk   (clk),
    .rstN  (rstN),
    .adv   (strb.adv),
    .vecIn (dynSig ^ statSig),
    .cntOut(popCnt)
  );

  // side pipeline: valid and indices ride with the count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < POP_LAT; i++) begin
        vPipe[i]    <= 1'b0;
        sIdxPipe[i] <= '0;
        dIdxPipe[i] <= '0;
      end
    end else if (strb.adv) begin
      vPipe[0]    <= dynV;
      sIdxPipe[0] <= statIdx;
      dIdxPipe[0] <= dynIdx;
      for (int i = 1; i < POP_LAT; i++) begin
        vPipe[i]    <= vPipe[i-1];
        sIdxPipe[i] <= sIdxPipe[i-1];
        dIdxPipe[i] <= dIdxPipe[i-1];
      end
    end
  end

  assign keep = vPipe[POP_LAT-1] && (popCnt <= thrQ);

  // threshold stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resWord  <= '0;
    end else if (strb.adv) begin
      resValid <= keep;
      resWord  <= {popCnt, sIdxPipe[POP_LAT-1], dIdxPipe[POP_LAT-1]};
    end
  end

  assign statSigOut = statSig;
  assign statIdxOut = statIdx;
  assign dynVOut    = dynV;
  assign dynSigOut  = dynSig;
  assign dynIdxOut  = dynIdx;

  // R7: frozen array keeps every output and stored value
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> $stable(resValid) && $stable(resWord) && $stable(dynSig)
                  && $stable(statSig) && $stable(dynV));

  // R5: a kept result respects the threshold in force when it was judged
  a_r5_thr_filter: assert property (@(posedge clk) disable iff (!rstN)
    resValid && $past(strb.adv) |-> resWord[RES_W-1 -: DIST_W] <= $past(thrQ));

  // R8: no result without a valid slot behind it
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(vPipe[POP_LAT-1]));
endmodule

// File: rtl/sca_datapath.sv
module sca_datapath
  import sca_pkg::*;
#(
  parameter int NUM_PE  = 4,
  parameter int SIG_W   = 32,
  parameter int IDX_W   = 27,
  parameter int DIST_W  = 10,
  parameter int POP_LAT = 2,
  localparam int RES_W  = DIST_W + 2*IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sca_strb_t               strb,
  input  logic [DIST_W-1:0]       thrQ,
  input  logic [SIG_W-1:0]        statSigIn,
  input  logic [IDX_W-1:0]        statIdxIn,
  input  logic [SIG_W-1:0]        dynSigIn,
  input  logic [IDX_W-1:0]        dynIdxIn,
  output logic [NUM_PE-1:0]       resValid,
  output logic [NUM_PE*RES_W-1:0] resWord
);
  logic [SIG_W-1:0] statSigL [NUM_PE+1];
  logic [IDX_W-1:0] statIdxL [NUM_PE+1];
  logic             dynVL    [NUM_PE+1];
  logic [SIG_W-1:0] dynSigL  [NUM_PE+1];
  logic [IDX_W-1:0] dynIdxL  [NUM_PE+1];

  assign statSigL[0] = statSigIn;
  assign statIdxL[0] = statIdxIn;
  assign dynVL[0]    = strb.dynLoad;
  assign dynSigL[0]  = dynSigIn;
  assign dynIdxL[0]  = dynIdxIn;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    sca_pe #(
      .SIG_W  (SIG_W),
      .IDX_W  (IDX_W),
      .DIST_W (DIST_W),
      .POP_LAT(POP_LAT)
    ) u_pe (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb),
      .thrQ      (thrQ),
      .statSigIn (statSigL[k]),
      .statIdxIn (statIdxL[k]),
      .dynVIn    (dynVL[k]),
      .dynSigIn  (dynSigL[k]),
      .dynIdxIn  (dynIdxL[k]),
      .statSigOut(statSigL[k+1]),
      .statIdxOut(statIdxL[k+1]),
      .dynVOut   (dynVL[k+1]),
      .dynSigOut (dynSigL[k+1]),
      .dynIdxOut (dynIdxL[k+1]),
      .resValid  (resValid[k]),
      .resWord   (resWord[k*RES_W +: RES_W])
    );

    // R1: reference data steps one PE per shift strobe
    a_r1_stat_shift: assert property (@(posedge clk) disable iff (!rstN)
      strb.statLoad |=> statSigL[k+1] == $past(statSigL[k])
                        && statIdxL[k+1] == $past(statIdxL[k]));

    // R2: database slot steps one PE per enabled edge
    a_r2_dyn_step: assert property (@(posedge clk) disable iff (!rstN)
      strb.adv |=> dynVL[k+1] == $past(dynVL[k])
                   && dynIdxL[k+1] == $past(dynIdxL[k]));
  end
endmodule

// File: rtl/sig_cmp_array.sv
module sig_cmp_array
  import sca_pkg::*;
#(
  parameter int NUM_PE  = 4,
  parameter int SIG_W   = 32,
  parameter int IDX_W   = 27,
  parameter int DIST_W  = 10,
  parameter int POP_LAT = 2,
  localparam int RES_W  = DIST_W + 2*IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    statShift,
  input  logic [SIG_W-1:0]        statSigIn,
  input  logic [IDX_W-1:0]        statIdxIn,
  input  logic                    dynValid,
  input  logic [SIG_W-1:0]        dynSigIn,
  input  logic [IDX_W-1:0]        dynIdxIn,
  input  logic                    thrWe,
  input  logic [DIST_W-1:0]       thrData,
  output logic [NUM_PE-1:0]       resValid,
  output logic [NUM_PE*RES_W-1:0] resWord
);
  sca_strb_t         strb;
  logic [DIST_W-1:0] thrQ;

  initial begin
    a_cfg_dist_w: assert (DIST_W >= $clog2(SIG_W + 1));
    a_cfg_pop_lat: assert (POP_LAT >= 2);
  end

  sca_ctrl #(
    .SIG_W (SIG_W),
    .DIST_W(DIST_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .statShift(statShift),
    .dynValid (dynValid),
    .thrWe    (thrWe),
    .thrData  (thrData),
    .strb     (strb),
    .thrQ     (thrQ)
  );

  sca_datapath #(
    .NUM_PE (NUM_PE),
    .SIG_W  (SIG_W),
    .IDX_W  (IDX_W),
    .DIST_W (DIST_W),
    .POP_LAT(POP_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .thrQ     (thrQ),
    .statSigIn(statSigIn),
    .statIdxIn(statIdxIn),
    .dynSigIn (dynSigIn),
    .dynIdxIn (dynIdxIn),
    .resValid (resValid),
    .resWord  (resWord)
  );
endmodule

// File: tb/sig_cmp_array_tb.sv
`timescale 1ns/1ps
module sig_cmp_array_tb;
  localparam int NPE = 4;
  localparam int SW  = 32;
  localparam int IW  = 27;
  localparam int DW  = 10;
  localparam int PL  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             statShift = 1'b0;
  logic [SW-1:0]    statSigIn = '0;
  logic [IW-1:0]    statIdxIn = '0;
  logic             dynValid = 1'b0;
  logic [SW-1:0]    dynSigIn = '0;
  logic [IW-1:0]    dynIdxIn = '0;
  logic             thrWe = 1'b0;
  logic [DW-1:0]    thrData = '0;
  logic [NPE-1:0]   resValid;
  logic [NPE*64-1:0] resWord;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curTag = "R9";
  logic [31:0] rngState = 32'h1234_5678;
  logic [SW-1:0] statSet [NPE];
  int statCount = 0;
  int dynCount = 0;

  always #2.5 clk = ~clk;

  sig_cmp_array #(.NUM_PE(NPE), .SIG_W(SW), .IDX_W(IW), .DIST_W(DW), .POP_LAT(PL)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .statShift(statShift),
    .statSigIn(statSigIn), .statIdxIn(statIdxIn), .dynValid(dynValid),
    .dynSigIn(dynSigIn), .dynIdxIn(dynIdxIn), .thrWe(thrWe), .thrData(thrData),
    .resValid(resValid), .resWord(resWord));

  // ---------------- behavioural reference model ----------------
  logic [SW-1:0] mSS [NPE];
  logic [IW-1:0] mSI [NPE];
  logic          mDV [NPE];
  logic [SW-1:0] mDS [NPE];
  logic [IW-1:0] mDI [NPE];
  logic          pV  [NPE][PL];
  int            pD  [NPE][PL];
  logic [IW-1:0] pS  [NPE][PL];
  logic [IW-1:0] pI  [NPE][PL];
  logic          mOutV [NPE];
  logic [63:0]   mOutW [NPE];
  int            mThr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NPE; k++) begin
        mSS[k] = '0; mSI[k] = '0; mDV[k] = 0; mDS[k] = '0; mDI[k] = '0;
        mOutV[k] = 0; mOutW[k] = '0;
        for (int s = 0; s < PL; s++) begin
          pV[k][s] = 0; pD[k][s] = 0; pS[k][s] = '0; pI[k][s] = '0;
        end
      end
      mThr = SW;
    end else begin
      if (enable) begin
        for (int k = 0; k < NPE; k++) begin
          mOutV[k] = pV[k][PL-1] && (pD[k][PL-1] <= mThr);
          mOutW[k] = {DW'(pD[k][PL-1]), pS[k][PL-1], pI[k][PL-1]};
          for (int s = PL-1; s > 0; s--) begin
            pV[k][s] = pV[k][s-1]; pD[k][s] = pD[k][s-1];
            pS[k][s] = pS[k][s-1]; pI[k][s] = pI[k][s-1];
          end
          pV[k][0] = mDV[k];
          pD[k][0] = $countones(mDS[k] ^ mSS[k]);
          pS[k][0] = mSI[k];
          pI[k][0] = mDI[k];
        end
        for (int k = NPE-1; k > 0; k--) begin
          mDV[k] = mDV[k-1]; mDS[k] = mDS[k-1]; mDI[k] = mDI[k-1];
        end
        mDV[0] = dynValid; mDS[0] = dynSigIn; mDI[0] = dynIdxIn;
        if (statShift) begin
          for (int k = NPE-1; k > 0; k--) begin
            mSS[k] = mSS[k-1]; mSI[k] = mSI[k-1];
          end
          mSS[0] = statSigIn; mSI[0] = statIdxIn;
        end
      end
      if (thrWe) mThr = int'(thrData);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int k = 0; k < NPE; k++) begin
        check(resValid[k] == mOutV[k], curTag, 64'(resValid[k]), 64'(mOutV[k]));
        if (mOutV[k] && resValid[k])
          check(resWord[k*64 +: 64] == mOutW[k], curTag, resWord[k*64 +: 64], mOutW[k]);
      end
    end
  end

  function automatic logic [31:0] rnd();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >> 17);
    rngState = rngState ^ (rngState << 5);
    return rngState;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      enable = 1; statShift = 0; dynValid = 0; thrWe = 0;
      @(negedge clk);
    end
  endtask

  task automatic writeThr(input int v);
    thrWe = 1; thrData = DW'(v); enable = 1; statShift = 0; dynValid = 0;
    @(negedge clk);
    thrWe = 0;
  endtask

  task automatic loadStatic();
    for (int i = 0; i < NPE; i++) begin
      logic [SW-1:0] v;
      v = rnd();
      statSet[NPE-1-i] = v;
      enable = 1; statShift = 1; statSigIn = v; statIdxIn = IW'(statCount);
      dynValid = 0; thrWe = 0;
      statCount++;
      @(negedge clk);
    end
    statShift = 0;
  endtask

  // mode: 0 random, 1 exact copies, 2 one-bit-off copies, 3 inverted copies
  task automatic streamDyn(input int n, input int gapPct, input int mode,
                           input int frzPct, input int twePct);
    for (int i = 0; i < n; i++) begin
      logic [SW-1:0] s;
      int pick;
      pick = int'(rnd() % NPE);
      s = rnd();
      if (mode == 1 && (rnd() % 2) == 0) s = statSet[pick];
      if (mode == 2) s = statSet[pick] ^ (SW'(1) << (rnd() % SW));
      if (mode == 3 && (rnd() % 2) == 0) s = ~statSet[pick];
      enable = (int'(rnd() % 100) >= frzPct);
      dynValid = (int'(rnd() % 100) >= gapPct);
      dynSigIn = s; dynIdxIn = IW'(dynCount);
      statShift = enable ? 1'b0 : rnd() % 2;
      statSigIn = rnd();
      thrWe = (int'(rnd() % 100) < twePct);
      thrData = DW'(rnd() % (SW + 1));
      dynCount++;
      @(negedge clk);
    end
    thrWe = 0; statShift = 0; dynValid = 0; enable = 1;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: outputs clear while and right after reset
    check(resValid == '0, "R9", 64'(resValid), 64'd0);
    rstN = 1;
    @(negedge clk);
    check(resValid == '0, "R9", 64'(resValid), 64'd0);

    curTag = "R1 R3 R4";
    loadStatic();
    curTag = "R2 R3 R4 R8";
    streamDyn(30, 30, 1, 0, 0);
    idle(NPE + PL + 4);
    curTag = "R2 R3 R4";
    streamDyn(20, 0, 0, 0, 0);
    idle(NPE + PL + 4);

    curTag = "R5 exact-only";
    writeThr(0);
    streamDyn(30, 10, 1, 0, 0);
    idle(NPE + PL + 4);
    curTag = "R5 near";
    writeThr(1);
    streamDyn(30, 10, 2, 0, 0);
    idle(NPE + PL + 4);
    curTag = "R5 thr31";
    writeThr(SW - 1);
    streamDyn(24, 0, 3, 0, 0);
    idle(NPE + PL + 4);
    curTag = "R5 thr32";
    writeThr(SW);
    streamDyn(24, 0, 3, 0, 0);
    idle(NPE + PL + 4);

    curTag = "R6";
    streamDyn(40, 10, 2, 0, 30);
    idle(NPE + PL + 4);
    writeThr(SW);

    curTag = "R7";
    streamDyn(60, 20, 1, 40, 0);
    idle(NPE + PL + 4);
    // directed freeze: results must hold, junk inputs ignored
    streamDyn(5, 0, 1, 0, 0);
    begin
      logic [NPE-1:0] holdV;
      logic [NPE*64-1:0] holdW;
      holdV = resValid; holdW = resWord;
      for (int i = 0; i < 4; i++) begin
        enable = 0; statShift = 1; dynValid = 1; dynSigIn = rnd(); statSigIn = rnd();
        @(negedge clk);
        check(resValid == holdV, "R7 hold valid", 64'(resValid), 64'(holdV));
        check(resWord == holdW, "R7 hold word", resWord[63:0], holdW[63:0]);
      end
    end
    idle(NPE + PL + 4);

    curTag = "R10";
    loadStatic();
    streamDyn(30, 10, 1, 0, 0);
    idle(NPE + PL + 4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired (R2) act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule